// File: doc/BRIEF.md
# RTC Tick Generator

This block turns a slow reference clock into the timing ticks of a real-time clock: a 1 Hz tick, plus periodic sample ticks at every power of two from 2 Hz to 512 Hz. The reference can run at one of three frequencies, chosen by a 2-bit selection input. Every rate comes out exactly on average, including references that do not divide down to 1024 Hz by a whole number.

Each tick sets its own sticky flag in a 16-bit status word. Software clears a flag by writing a one to it. An interrupt output is raised whenever a flag is set and its matching enable bit is also set. The registered 1 Hz tick is also driven out for the time-of-day and alarm logic next to this block.

The divider is a two-state machine. In HOLD, all counters sit at zero. In RUN, the cycle counter advances. The transition HOLD to RUN is taken at the first edge where the module is enabled and the selection is unchanged. The transition RUN to HOLD is taken at any edge where the enable is low or the selection differs from the value sampled at the previous edge.

Top module: `rtc_tick_gen`

## Requirements
- R1: While reset is held, and just after it, status is 0, irq is 0 and tick_1hz is 0.
- R2: With freq_sel 0 (32768 Hz), and with the value 3 treated the same way, the 512 Hz flag is set every 64 reference cycles. In one second each flag is set exactly at its own rate.
- R3: With freq_sel 2 (38400 Hz), base periods alternate between 37 and 38 cycles. The 512 Hz flag is set every 75 cycles, and one second of 38400 cycles yields each rate's exact count.
- R4: With freq_sel 1 (32000 Hz), base periods repeat 31, 31, 31, 32 cycles. Consecutive 512 Hz intervals alternate between 62 and 63 cycles and every adjacent pair sums to 125. One second of 32000 cycles yields each rate's exact count.
- R5: Status bit map: bits 15 down to 8 carry 512, 256, 128, 64, 32, 16, 8 and 4 Hz. Bit 7 carries 2 Hz and bit 4 carries 1 Hz. Bits 0 to 3, 5 and 6 always read 0.
- R6: tick_1hz is high for exactly one cycle per second, in the same cycle that status bit 4 is set.
- R7: Writing clr_data with clr_wr high clears exactly the status bits written as one. Bits written as zero keep their value, and a set flag otherwise stays set.
- R8: If a flag's tick and its clear arrive in the same cycle, the flag ends up set.
- R9: irq is high exactly when some status bit and the same bit of irq_en are both 1.
- R10: While enable is 0, no flag is set. The first 512 Hz flag is set at the 64th clock edge after the edge that first samples enable high (32768 Hz selection).
- R11: A change of freq_sel restarts the divider. The first 512 Hz flag is set at the 65th edge after the edge that sees the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (32768, 32000 or 38400 Hz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low holds the divider in HOLD |
| freq_sel | input | 2 | Reference selection: 0 = 32768, 1 = 32000, 2 = 38400, 3 = 32768 |
| irq_en | input | 16 | Per-flag interrupt enables |
| clr_wr | input | 1 | Strobe for the write-one-to-clear of status |
| clr_data | input | 16 | Bits to clear when clr_wr is high |
| status | output | 16 | Sticky tick flags |
| irq | output | 1 | OR of status AND irq_en |
| tick_1hz | output | 1 | One-cycle 1 Hz pulse for the time counters |

## Verification
The divider is run for one full second at each of the three reference selections, counting how often every flag is set. These counts show that each selection reaches the exact average rate and that each rate lands on the right status bit. The spacing between consecutive 512 Hz flags separates the even 64-cycle division, the 37/38 alternation and the 31/31/31/32 pattern, so a wrong period pattern is caught even when the one-second total happens to match. Short directed sequences pin down the restart timing after enable and after a selection change (using code 3), set-over-clear priority, selective clearing and interrupt masking.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

    typedef enum logic [1:0] {
        SEL_32768 = 2'd0,
        SEL_32000 = 2'd1,
        SEL_38400 = 2'd2,
        SEL_ALT   = 2'd3
    } ref_sel_e;

    typedef enum logic {
        DIV_HOLD = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    localparam int STAT_W     = 16;
    localparam int HALVE_N    = 10;
    localparam int CYC_W      = 6;
    localparam int P_EVEN     = 32;
    localparam int P_32000_LO = 31;
    localparam int P_38400_LO = 37;
    localparam logic [STAT_W-1:0] FLAG_MASK = 16'hFF90;

    // Stage k of the halving chain ticks at 2^(9-k) Hz.
    // Stages 0..7 go to bits 15..8, stage 8 (2 Hz) to bit 7,
    // and stage 9 (1 Hz) to bit 4.
    function automatic int stage_bit(input int k);
        if (k <= 7)      return 15 - k;
        else if (k == 8) return 7;
        else             return 4;
    endfunction

endpackage

// File: rtl/rtc_base_div.sv
module rtc_base_div
    import rtc_tick_pkg::*;
#(
    parameter int W = CYC_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_ok,
    input  logic [1:0] sel,
    output logic       base_tick
);

    div_state_e state_q, state_d;
    logic [W-1:0] cyc_q;
    logic [1:0]   phase_q;
    logic [W-1:0] period;

    // Period of the current base cycle, taken from the selection and the phase.
    always_comb begin
        unique case (ref_sel_e'(sel))
            SEL_32000: period = W'(P_32000_LO) + W'(phase_q == 2'd3);
            SEL_38400: period = W'(P_38400_LO) + W'(phase_q[0]);
            default:   period = W'(P_EVEN);
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIV_HOLD;
        else        state_q <= state_d;
    end

    // Next state and output
    always_comb begin
        state_d   = state_q;
        base_tick = 1'b0;
        unique case (state_q)
            DIV_HOLD: begin
                if (run_ok) state_d = DIV_RUN;
            end
            DIV_RUN: begin
                if (!run_ok) state_d = DIV_HOLD;
                else         base_tick = (cyc_q == period - W'(1));
            end
            default: state_d = DIV_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            phase_q <= '0;
        end else if (state_q == DIV_HOLD || !run_ok) begin
            cyc_q   <= '0;
            phase_q <= '0;
        end else if (base_tick) begin
            cyc_q   <= '0;
            phase_q <= phase_q + 2'd1;
        end else begin
            cyc_q   <= cyc_q + W'(1);
        end
    end

    // R10: a held or restarted divider produces no tick in the following cycle
    assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> !base_tick);

    // R3: the cycle counter never passes the longest period of any selection
    assert_cyc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q < W'(P_38400_LO + 1));

endmodule

// File: rtl/rtc_halver.sv
module rtc_halver
    import rtc_tick_pkg::*;
#(
    parameter int N = HALVE_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         base_tick,
    output logic [N-1:0] stage_tick
);

    logic [N-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart)   cnt_q <= '0;
        else if (base_tick) cnt_q <= cnt_q + N'(1);
    end

    for (genvar k = 0; k < N; k++) begin : g_stage
        assign stage_tick[k] = base_tick & (&cnt_q[k:0]);
        if (k > 0) begin : g_nest
            // R5: each slower rate only ticks on a cycle where the next faster rate also ticks
            assert_nest_R5: assert property (@(posedge clk) disable iff (!rst_n)
                stage_tick[k] |-> stage_tick[k-1]);
        end
    end

endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
    import rtc_tick_pkg::*;
#(
    parameter int N = HALVE_N,
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  stage_tick,
    input  logic          clr_wr,
    input  logic [SW-1:0] clr_data,
    input  logic [SW-1:0] irq_en,
    output logic [SW-1:0] status,
    output logic          irq,
    output logic          tick_1hz
);

    logic [SW-1:0] set_vec;
    logic [SW-1:0] clr_vec;
    logic [SW-1:0] status_q;
    logic          tick_q;

    always_comb begin
        set_vec = '0;
        for (int k = 0; k < N; k++) set_vec[stage_bit(k)] = stage_tick[k];
    end

    assign clr_vec = clr_wr ? clr_data : '0;

    // A set in the same cycle as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            tick_q   <= 1'b0;
        end else begin
            status_q <= ((status_q & ~clr_vec) | set_vec) & FLAG_MASK;
            tick_q   <= stage_tick[N-1];
        end
    end

    assign status   = status_q;
    assign tick_1hz = tick_q;
    assign irq      = |(status_q & irq_en);

    for (genvar i = 0; i < SW; i++) begin : g_chk
        if (FLAG_MASK[i]) begin : g_live
            // R7: a flag holds until written with a one
            assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (status_q[i] && !(clr_wr && clr_data[i])) |=> status_q[i]);
            // R8: a tick always leaves its flag set, even with a clear pending
            assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> status_q[i]);
        end
    end

    // R6: the 1 Hz pulse lasts one cycle
    assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
    import rtc_tick_pkg::*;
#(
    parameter int N  = HALVE_N,
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [1:0]    freq_sel,
    input  logic [SW-1:0] irq_en,
    input  logic          clr_wr,
    input  logic [SW-1:0] clr_data,
    output logic [SW-1:0] status,
    output logic          irq,
    output logic          tick_1hz
);

    logic [1:0]   sel_q;
    logic         sel_changed;
    logic         restart;
    logic         base_tick;
    logic [N-1:0] stage_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= freq_sel;
    end

    assign sel_changed = (freq_sel != sel_q);
    assign restart     = !enable || sel_changed;

    rtc_base_div #(.W(CYC_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_ok    (!restart),
        .sel       (freq_sel),
        .base_tick (base_tick)
    );

    rtc_halver #(.N(N)) u_halve (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .base_tick  (base_tick),
        .stage_tick (stage_tick)
    );

    rtc_flag_bank #(.N(N), .SW(SW)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_tick (stage_tick),
        .clr_wr     (clr_wr),
        .clr_data   (clr_data),
        .irq_en     (irq_en),
        .status     (status),
        .irq        (irq),
        .tick_1hz   (tick_1hz)
    );

    // R11: a selection change suppresses the 1 Hz pulse two cycles later
    assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_changed |-> ##2 !tick_1hz);

endmodule

// File: tb/rtc_tick_gen_tb.sv
module rtc_tick_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  freq_sel = 2'd0;
    logic [15:0] irq_en = '0;
    logic        clr_wr = 1'b0;
    logic [15:0] clr_data = '0;
    logic [15:0] status;
    logic        irq;
    logic        tick_1hz;

    int total = 0;
    int bad = 0;

    // scoreboard queues: expected flag counts per window
    int    q_bit[$];
    int    q_cnt[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    rtc_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .freq_sel(freq_sel),
        .irq_en(irq_en), .clr_wr(clr_wr), .clr_data(clr_data),
        .status(status), .irq(irq), .tick_1hz(tick_1hz)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_wr = 1'b1; clr_data = 16'hFFFF;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = '0;
    endtask

    // Driver: restarts the divider, pushes expected counts, runs one second plus margin.
    // mode 0: fixed 64-cycle 512 Hz spacing, 1: fixed 75, 2: alternating 62/63.
    task automatic run_window(input logic [1:0] sel, input int f, input int mode, input string tag);
        int cnt[16];
        int prev, last_iv, iv_bad, pulses, coinc;
        logic [15:0] st;
        @(negedge clk);
        enable = 1'b0;
        clear_all();
        freq_sel = sel;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            q_bit.push_back(15 - k); q_cnt.push_back(512 >> k); q_tag.push_back({tag, "/R5"});
        end
        q_bit.push_back(7); q_cnt.push_back(2); q_tag.push_back({tag, "/R5"});
        q_bit.push_back(4); q_cnt.push_back(1); q_tag.push_back({tag, "/R5"});
        foreach (cnt[b]) cnt[b] = 0;
        for (int b = 0; b < 7; b++) begin
            if (b != 4) begin
                q_bit.push_back(b); q_cnt.push_back(0); q_tag.push_back("R5 unused bit");
            end
        end
        prev = -1; last_iv = 0; iv_bad = 0; pulses = 0; coinc = 0;
        enable = 1'b1;
        for (int n = 1; n <= f + 20; n++) begin
            @(negedge clk);
            st = status;
            for (int b = 0; b < 16; b++) if (st[b]) cnt[b]++;
            if (tick_1hz) begin
                pulses++;
                if (st[4]) coinc++;
            end
            if (st[15]) begin
                if (prev >= 0) begin
                    int iv;
                    iv = n - prev;
                    if (mode == 0 && iv != 64) iv_bad++;
                    if (mode == 1 && iv != 75) iv_bad++;
                    if (mode == 2) begin
                        if (iv != 62 && iv != 63) iv_bad++;
                        if (last_iv != 0 && last_iv + iv != 125) iv_bad++;
                    end
                    last_iv = iv;
                end
                prev = n;
            end
            clr_wr = |st; clr_data = st;
        end
        @(negedge clk);
        clr_wr = 1'b0; clr_data = '0;
        // monitor: pop expected items and compare against measured counts
        while (q_bit.size() > 0) begin
            int b, e;
            string t;
            b = q_bit.pop_front(); e = q_cnt.pop_front(); t = q_tag.pop_front();
            check(cnt[b] == e, $sformatf("%s bit%0d count", t, b), cnt[b], e);
        end
        check(iv_bad == 0, {tag, " 512Hz spacing"}, iv_bad, 0);
        check(pulses == 1, "R6 tick_1hz pulses per second", pulses, 1);
        check(coinc == 1, "R6 tick_1hz with status bit 4", coinc, 1);
    endtask

    initial begin
        int n;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(status == 0 && irq == 0 && tick_1hz == 0, "R1 in reset", int'(status), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 0 && irq == 0, "R1 after reset", int'(status), 0);

        // R10 hold while disabled
        repeat (300) @(negedge clk);
        check(status == 0, "R10 disabled no flags", int'(status), 0);

        // R10 first flag timing after enable
        enable = 1'b1;
        n = 0;
        while (!status[15] && n < 200) begin @(negedge clk); n++; end
        check(n == 65, "R10 first 512Hz flag edge", n, 65);

        // R8 set wins over clear in the same cycle
        enable = 1'b0;
        clear_all();
        enable = 1'b1;
        repeat (64) @(negedge clk);
        clr_wr = 1'b1; clr_data = 16'h8000;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = '0;
        check(status[15] == 1'b1, "R8 set beats clear", status[15], 1);

        // R7 selective clear; first 256 Hz flag at edge 128 (n=129)
        repeat (64) @(negedge clk);
        check(status[15:14] == 2'b11, "R7 both flags held", int'(status[15:14]), 3);
        clr_wr = 1'b1; clr_data = 16'h406F;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = '0;
        check(status[15:14] == 2'b10, "R7 only written bit cleared", int'(status[15:14]), 2);

        // R9 interrupt masking
        irq_en = 16'h0000; #1;
        check(irq == 1'b0, "R9 masked", irq, 0);
        irq_en = 16'h4000; #1;
        check(irq == 1'b0, "R9 enable on clear bit", irq, 0);
        irq_en = 16'h8000; #1;
        check(irq == 1'b1, "R9 enabled set bit", irq, 1);
        @(negedge clk);
        clr_wr = 1'b1; clr_data = 16'h8000;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = '0;
        check(irq == 1'b0, "R9 cleared flag drops irq", irq, 0);
        irq_en = '0;

        // R11 selection change restarts the chain; code 3 acts as 32768 Hz (R2)
        enable = 1'b0;
        clear_all();
        freq_sel = 2'd0;
        @(negedge clk);
        enable = 1'b1;
        repeat (40) @(negedge clk);
        freq_sel = 2'd3;
        n = 0;
        while (!status[15] && n < 200) begin @(negedge clk); n++; end
        check(n == 66, "R11 first flag after selection change", n, 66);
        clr_wr = 1'b1; clr_data = 16'hFFFF;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = '0;
        n = 1;
        while (!status[15] && n < 200) begin @(negedge clk); n++; end
        check(n == 64, "R2 code 3 spacing", n, 64);

        // one-second windows
        run_window(2'd0, 32768, 0, "R2 32768");
        run_window(2'd2, 38400, 1, "R3 38400");
        run_window(2'd1, 32000, 2, "R4 32000");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule